// File: doc/BRIEF.md
# UART Interrupt Status Unit

This block produces the interrupts of a simple memory-mapped UART. It holds one received byte and one byte waiting to be sent, and it keeps four live status flags: receive buffer full, transmit buffer full, receive overrun and transmit overrun. A sticky pending register collects interrupt causes. Software clears it by writing ones. Each pending bit is ANDed with an enable bit from the control register. The result drives four separate interrupt lines and one combined line. Serial shifting and baud timing are not part of the block. Received bytes arrive on a valid/ready input, and bytes to send leave on a valid/ready output.

The pending bits for receive, receive overrun and transmit overrun are refreshed from live status on every cycle. A cause that arrives while its enable is off is therefore still pending, and it fires one clock after software enables it. Clearing the receive pending bit has no effect while the receive buffer is still full. The transmit pending bit is set only when a byte leaves on the output handshake.

Back-pressure rules:
- The receive input never back-pressures: `rx_ready` is always high. A byte offered while the buffer is full, with no data-register read in the same cycle, is dropped and flags an overrun.
- The transmit output holds `tx_valid` high, with `tx_data` stable, until the consumer raises `tx_ready`.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset, status, control, pending and all interrupt outputs are zero, `tx_valid` is low and every register reads zero.
- R2: A beat on the receive input stores the byte and sets status bit 1 (receive full). A `reg_rd` at address 0 returns the byte and clears receive full, unless a new byte is accepted in that same cycle.
- R3: A byte that arrives while receive full is set, with no address-0 read in the same cycle, is dropped and sets status bit 3 (receive overrun). That bit stays set until software writes status (address 1) with bit 3 high.
- R4: A write to address 0 while the transmit buffer is empty, or while its byte is leaving in that cycle, loads the byte and sets status bit 0 (transmit full). `tx_valid` and `tx_data` then hold until `tx_ready`, and the handshake clears transmit full. A write while the buffer is full and not leaving is dropped and sets status bit 2 (transmit overrun). Writing status with bit 2 high clears it.
- R5: The pending register at address 3 holds: bit 3 receive overrun, bit 2 transmit overrun, bit 1 receive, bit 0 transmit. Bits 3..1 are ORed each cycle with status bits 3..1 whatever the enables are. Bit 0 is set only by a transmit handshake. All four bits are sticky.
- R6: A write to address 3 clears every pending bit whose write-data bit is one. A set in the same cycle wins, so receive pending cannot be cleared while receive full remains.
- R7: The control register at address 2 holds the enables at bits 5..2 (receive overrun, transmit overrun, receive, transmit). Its other bits read zero. Each interrupt output is the registered AND of its pending bit and its enable, and it changes one clock after the event or write that causes the change.
- R8: `irq_any` is high exactly when at least one of the four interrupt outputs is high.
- R9: If a cause is pending while its enable is off, the write that sets the enable raises the matching interrupt on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Always high; the input is never stalled |
| rx_data | input | DATA_W | Received byte |
| tx_valid | output | 1 | Transmit byte waiting |
| tx_ready | input | 1 | Consumer takes the transmit byte |
| tx_data | output | DATA_W | Byte to send |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; it only has an effect at address 0 |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 control, 3 pending |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, available in the same cycle |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
Some behaviours are checked by assertions on every cycle:
- Each interrupt output equals its pending bit ANDed with its enable.
- `irq_any` matches the four lines.
- Receive pending stays set while receive full stays set.
- Overrun flags stay sticky unless cleared.
- A transmit handshake always leaves transmit pending set.
- `tx_valid` holds, with stable data, under back-pressure.

Other behaviours depend on a sequence of events, so only the bench scenarios can show them:
- An interrupt fires when it is enabled after its cause arrived.
- A clear is overridden by a byte that is still buffered.
- A byte arriving in the same cycle as a data read is kept, not flagged as an overrun.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int unsigned NIRQ   = 4;
  localparam int unsigned EN_LSB = 2;
  // interrupt and status bit positions (shared by status, pending and enables)
  localparam int unsigned IB_TX  = 0;
  localparam int unsigned IB_RX  = 1;
  localparam int unsigned IB_TXO = 2;
  localparam int unsigned IB_RXO = 3;

  typedef enum logic [1:0] {
    RA_DATA   = 2'd0,
    RA_STATUS = 2'd1,
    RA_CTRL   = 2'd2,
    RA_PEND   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/uart_irq_rxhold.sv
`timescale 1ns/1ps
module uart_irq_rxhold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              pop,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] buf_q,
  output logic              full_q,
  output logic              full_d,
  output logic              ovr_q,
  output logic              ovr_d
);
  logic accept;
  logic ovr_set;

  always_comb begin
    accept  = in_valid && (!full_q || pop);
    ovr_set = in_valid && full_q && !pop;
    if (accept)   full_d = 1'b1;
    else if (pop) full_d = 1'b0;
    else          full_d = full_q;
    ovr_d = ovr_set | (ovr_q & ~ovr_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) buf_q <= in_data;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  AST_RX_FULL_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> full_q); // R2
  AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q); // R3
  AST_RX_DROP_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full_q && !pop) |=> $stable(buf_q)); // R3
endmodule

// File: rtl/uart_irq_txhold.sv
`timescale 1ns/1ps
module uart_irq_txhold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              ovr_clr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              done,
  output logic              full_q,
  output logic              ovr_q,
  output logic              ovr_d
);
  logic ovr_set;
  logic load;
  logic full_d;

  always_comb begin
    done    = full_q && out_ready;
    ovr_set = push && full_q && !done;
    load    = push && !ovr_set;
    if (load)      full_d = 1'b1;
    else if (done) full_d = 1'b0;
    else           full_d = full_q;
    ovr_d = ovr_set | (ovr_q & ~ovr_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (load) out_data <= push_data;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign out_valid = full_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4
  AST_TX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q); // R4
endmodule

// File: rtl/uart_irq_pend.sv
`timescale 1ns/1ps
module uart_irq_pend #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] en_q,
  output logic [N-1:0] irq_q,
  output logic         irq_any_q
);
  logic [N-1:0] pend_d;
  logic [N-1:0] en_d;
  logic [N-1:0] irq_d;

  assign en_d = en_we ? en_wdata : en_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      pend_d[g] = set_vec[g] | (pend_q[g] & ~(clr_we & clr_mask[g]));
      irq_d[g]  = pend_d[g] & en_d[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        irq_q[g]  <= 1'b0;
      end else begin
        pend_q[g] <= pend_d[g];
        irq_q[g]  <= irq_d[g];
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> pend_q[g]); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      irq_any_q <= 1'b0;
    end else begin
      en_q      <= en_d;
      irq_any_q <= |irq_d;
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (pend_q & en_q)); // R7
  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any_q == (irq_q != '0)); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0 && !clr_we) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R5
endmodule

// File: rtl/uart_irq_unit.sv
`timescale 1ns/1ps
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_txovr,
  output logic              irq_rxovr,
  output logic              irq_any
);
  logic wr_data, wr_stat, wr_ctrl, wr_pend, rd_data;

  logic [DATA_W-1:0] rx_buf;
  logic rx_full_q, rx_full_d, rx_ovr_q, rx_ovr_d;
  logic tx_done, tx_full_q, tx_ovr_q, tx_ovr_d;

  logic [NIRQ-1:0] set_vec, pend_q, en_q, irq_q;

  always_comb begin
    wr_data = reg_wr && (reg_addr == RA_DATA);
    wr_stat = reg_wr && (reg_addr == RA_STATUS);
    wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    wr_pend = reg_wr && (reg_addr == RA_PEND);
    rd_data = reg_rd && (reg_addr == RA_DATA);
  end

  assign rx_ready = 1'b1;

  uart_irq_rxhold #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(rx_valid),
    .in_data (rx_data),
    .pop     (rd_data),
    .ovr_clr (wr_stat && reg_wdata[IB_RXO]),
    .buf_q   (rx_buf),
    .full_q  (rx_full_q),
    .full_d  (rx_full_d),
    .ovr_q   (rx_ovr_q),
    .ovr_d   (rx_ovr_d)
  );

  uart_irq_txhold #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_data),
    .push_data(reg_wdata),
    .ovr_clr  (wr_stat && reg_wdata[IB_TXO]),
    .out_ready(tx_ready),
    .out_valid(tx_valid),
    .out_data (tx_data),
    .done     (tx_done),
    .full_q   (tx_full_q),
    .ovr_q    (tx_ovr_q),
    .ovr_d    (tx_ovr_d)
  );

  // live causes: overruns and receive full follow next status, transmit is an event
  always_comb begin
    set_vec         = '0;
    set_vec[IB_RXO] = rx_ovr_d;
    set_vec[IB_TXO] = tx_ovr_d;
    set_vec[IB_RX]  = rx_full_d;
    set_vec[IB_TX]  = tx_done;
  end

  uart_irq_pend #(.N(NIRQ)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_we   (wr_pend),
    .clr_mask (reg_wdata[NIRQ-1:0]),
    .en_we    (wr_ctrl),
    .en_wdata (reg_wdata[EN_LSB +: NIRQ]),
    .pend_q   (pend_q),
    .en_q     (en_q),
    .irq_q    (irq_q),
    .irq_any_q(irq_any)
  );

  assign irq_tx    = irq_q[IB_TX];
  assign irq_rx    = irq_q[IB_RX];
  assign irq_txovr = irq_q[IB_TXO];
  assign irq_rxovr = irq_q[IB_RXO];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_DATA:   reg_rdata = rx_buf;
      RA_STATUS: begin
        reg_rdata[IB_RXO] = rx_ovr_q;
        reg_rdata[IB_TXO] = tx_ovr_q;
        reg_rdata[IB_RX]  = rx_full_q;
        reg_rdata[IB_TX]  = tx_full_q;
      end
      RA_CTRL:   reg_rdata[EN_LSB +: NIRQ] = en_q;
      default:   reg_rdata[NIRQ-1:0] = pend_q;
    endcase
  end

  AST_RX_PEND_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_q |-> pend_q[IB_RX]); // R6
  AST_OVR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr_q |-> pend_q[IB_RXO]) and (tx_ovr_q |-> pend_q[IB_TXO])); // R5
  AST_TX_DONE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> pend_q[IB_TX]); // R5
endmodule

// File: tb/tb_uart_irq_unit.sv
`timescale 1ns/1ps
module tb_uart_irq_unit;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [DW-1:0] rx_data = '0, reg_wdata = '0;
  logic [1:0] reg_addr = '0;
  logic rx_ready, tx_valid;
  logic [DW-1:0] tx_data, reg_rdata;
  logic irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_irq_unit #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr),
    .irq_rxovr(irq_rxovr), .irq_any(irq_any)
  );

  // reference state; bit order of status/pending/enables: 3 rxo, 2 txo, 1 rx, 0 tx
  logic [DW-1:0] m_rxbuf, m_txbuf;
  logic m_rxf, m_rxo, m_txf, m_txo;
  logic [3:0] m_en, m_pend, m_irq;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] status_of();
    return {m_rxo, m_txo, m_rxf, m_txf};
  endfunction

  function automatic logic [DW-1:0] read_of(input logic [1:0] a);
    case (a)
      2'd0: return m_rxbuf;
      2'd1: return {4'b0, status_of()};
      2'd2: return {2'b0, m_en, 2'b00};
      default: return {4'b0, m_pend};
    endcase
  endfunction

  function automatic logic [3:0] pend_next(input logic [3:0] p, input logic clr,
                                           input logic [3:0] mask, input logic [3:0] live);
    return (p & ~(clr ? mask : 4'b0)) | live;
  endfunction

  task automatic model_reset();
    m_rxbuf = '0; m_txbuf = '0;
    m_rxf = 0; m_rxo = 0; m_txf = 0; m_txo = 0;
    m_en = '0; m_pend = '0; m_irq = '0;
  endtask

  task automatic model_step();
    logic rd0, wr0, wr1, wr2, wr3, done, rx_ovr, tx_ovr;
    rd0 = reg_rd && reg_addr == 2'd0;
    wr0 = reg_wr && reg_addr == 2'd0;
    wr1 = reg_wr && reg_addr == 2'd1;
    wr2 = reg_wr && reg_addr == 2'd2;
    wr3 = reg_wr && reg_addr == 2'd3;
    done = m_txf && tx_ready;
    rx_ovr = rx_valid && m_rxf && !rd0;
    tx_ovr = wr0 && m_txf && !done;
    m_rxo = rx_ovr | (m_rxo & ~(wr1 & reg_wdata[3]));
    m_txo = tx_ovr | (m_txo & ~(wr1 & reg_wdata[2]));
    if (rx_valid && !rx_ovr) begin m_rxbuf = rx_data; m_rxf = 1; end
    else if (rd0) m_rxf = 0;
    if (wr0 && !tx_ovr) begin m_txbuf = reg_wdata; m_txf = 1; end
    else if (done) m_txf = 0;
    m_pend = pend_next(m_pend, wr3, reg_wdata[3:0], {m_rxo, m_txo, m_rxf, done});
    if (wr2) m_en = reg_wdata[5:2];
    m_irq = m_pend & m_en;
  endtask

  task automatic compare_all();
    chk("R7 irq vector", {irq_rxovr, irq_txovr, irq_rx, irq_tx}, m_irq);
    chk("R8 irq_any", irq_any, |m_irq);
    chk("R4 tx_valid", tx_valid, m_txf);
    if (m_txf) chk("R4 tx_data", tx_data, m_txbuf);
    chk("R2 rx_ready", rx_ready, 1'b1);
    case (reg_addr)
      2'd0: chk("R2 data read", reg_rdata, read_of(reg_addr));
      2'd1: chk("R3 status read", reg_rdata, read_of(reg_addr));
      2'd2: chk("R7 control read", reg_rdata, read_of(reg_addr));
      default: chk("R5 pending read", reg_rdata, read_of(reg_addr));
    endcase
  endtask

  task automatic cycle(input logic rv, input logic [DW-1:0] rd_byte, input logic tr,
                       input logic w, input logic r, input logic [1:0] a,
                       input logic [DW-1:0] wd);
    @(negedge clk);
    rx_valid = rv; rx_data = rd_byte; tx_ready = tr;
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = wd;
    #1;
    compare_all();
    model_step();
  endtask

  task automatic peek(input logic [1:0] a);
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, a, '0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7321);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1 irq_any", irq_any, 1'b0);
    chk("R1 tx_valid", tx_valid, 1'b0);
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0];
      #1;
      chk("R1 register read", reg_rdata, '0);
    end

    // R9: byte arrives with receive enable off, enabled later
    cycle(1, 8'h5A, 0, 0, 0, 2'd3, '0);
    peek(2'd3);
    chk("R5 rx pending without enable", reg_rdata[1], 1'b1);
    chk("R9 irq_rx stays low while disabled", irq_rx, 1'b0);
    cycle(0, '0, 0, 1, 0, 2'd2, 8'h08);
    peek(2'd2);
    chk("R9 irq_rx after enable", irq_rx, 1'b1);

    // R6: clearing rx pending while the byte is still buffered has no effect
    cycle(0, '0, 0, 1, 0, 2'd3, 8'h02);
    peek(2'd3);
    chk("R6 rx pending kept by full buffer", reg_rdata[1], 1'b1);
    chk("R6 irq_rx kept", irq_rx, 1'b1);
    cycle(0, '0, 0, 0, 1, 2'd0, '0);   // pop 0x5A
    cycle(0, '0, 0, 1, 0, 2'd3, 8'h02);
    peek(2'd1);
    chk("R2 receive full cleared by read", reg_rdata[1], 1'b0);
    chk("R6 irq_rx dropped after clear", irq_rx, 1'b0);

    // R2: arrival in the same cycle as a read is not an overrun
    cycle(1, 8'h11, 0, 0, 0, 2'd0, '0);
    cycle(1, 8'h22, 0, 0, 1, 2'd0, '0);
    peek(2'd1);
    chk("R2 same-cycle read and arrival: no overrun", reg_rdata[3], 1'b0);
    peek(2'd0);
    chk("R2 new byte kept", reg_rdata, 8'h22);

    // R3: overrun and its clear
    cycle(1, 8'h33, 0, 1, 0, 2'd2, 8'h20);  // enable rxo interrupt
    peek(2'd1);
    chk("R3 overrun flagged", reg_rdata[3], 1'b1);
    chk("R3 irq_rxovr", irq_rxovr, 1'b1);
    peek(2'd0);
    chk("R3 dropped byte leaves buffer", reg_rdata, 8'h22);
    cycle(0, '0, 0, 1, 0, 2'd1, 8'h08);
    peek(2'd1);
    chk("R3 overrun cleared", reg_rdata[3], 1'b0);

    // R4 / R6: transmit hold, overrun, set beats clear on done
    cycle(0, '0, 0, 1, 0, 2'd2, 8'h04);
    cycle(0, '0, 0, 1, 0, 2'd0, 8'hA5);
    peek(2'd1);
    chk("R4 tx_valid held", tx_valid, 1'b1);
    cycle(0, '0, 0, 1, 0, 2'd0, 8'h3C);
    peek(2'd1);
    chk("R4 transmit overrun", reg_rdata[2], 1'b1);
    chk("R4 data unchanged", tx_data, 8'hA5);
    cycle(0, '0, 1, 1, 0, 2'd3, 8'h01);
    peek(2'd3);
    chk("R6 tx pending set wins over clear", reg_rdata[0], 1'b1);
    chk("R7 irq_tx", irq_tx, 1'b1);
    chk("R8 irq_any", irq_any, 1'b1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      cycle(($urandom_range(0, 3) == 0), 8'($urandom), ($urandom_range(0, 2) == 0),
            (op == 2'd1), (op == 2'd2), 2'($urandom), 8'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule